// File: doc/BRIEF.md
# Multi-Stage Sequential Trigger Unit

This block watches a bundle of probed signals on every clock and emits a one-cycle trigger pulse after a programmed chain of conditions has been satisfied in order. Each stage compares every probed signal against its own constant, using a per-bit care mask and one of six operators. A signal can be left out of a stage. The results of the included signals are then reduced with either AND or OR. Each stage may also have a cycle limit. If that limit expires, the hunt stops and a sticky timeout flag is raised. A run-now option fires the trigger straight after arming.

Configuration is written one field at a time through a write port. The port selects a field code, a stage index and a signal index, and carries one data word. Arming starts the hunt at stage 0.

The sequencer has three states:
- `ST_IDLE`: waiting for an arm.
- `ST_HUNT`: evaluating the current stage.
- `ST_FIRE`: the trigger cycle.

Its transitions are:
- `ST_IDLE` goes to `ST_HUNT` on an arm, or to `ST_FIRE` on an arm when run-now is set.
- `ST_HUNT` stays in `ST_HUNT` on a match of a stage that is not the last one, and advances the stage index.
- `ST_HUNT` goes to `ST_FIRE` when the last active stage matches.
- `ST_HUNT` goes to `ST_IDLE` when the stage limit expires, and raises the timeout flag.
- `ST_HUNT` restarts at stage 0 on an arm.
- `ST_FIRE` always goes to `ST_IDLE` one cycle later.

Top module: `seq_trig`

## Requirements
- R1: After reset, trig_o, busy_o, timeout_o and stage_o are all 0. All signals are excluded from all stages. Masks are all ones, operators are equality, combine is AND, limits are 0, the active stage count is MAX_STG and run-now is clear.
- R2: Stages are satisfied strictly in order. stage_o shows the stage being evaluated, and it advances by one on the cycle after that stage matches. The trigger fires only when the last active stage matches after all earlier stages have matched.
- R3: Field code 5 sets the number of active stages. data[STG_W-1:0] holds the count minus one.
- R4: Field code 2 has the include bit at bit 0. An excluded signal has no effect on the stage result. A stage with no included signal matches on its first evaluated cycle.
- R5: Field code 2 holds the operator in bits 3:1, all compares unsigned. The codes are 0 equal, 1 not-equal, 2 greater, 3 greater-or-equal, 4 less, 5 less-or-equal. Codes 6 and 7 never match. Field code 0 holds the compare constant.
- R6: Field code 1 holds a per-bit care mask, where 1 means the bit is compared. The mask applies only to equal and not-equal.
- R7: Field code 3 bit 0 selects how the included results are combined within a stage: 0 is AND, 1 is OR.
- R8: Field code 4 sets the stage limit L. When L > 0, a stage must match within the L cycles that follow its entry. Otherwise busy_o drops and timeout_o becomes 1 and stays 1 until the next arm. L = 0 means no limit.
- R9: Field code 6 bit 0 is run-now. With it set, an arm makes trig_o high on the next cycle without evaluating any stage.
- R10: When the probes match in cycle n, trig_o is high for exactly cycle n+1 and busy_o is low from then on. Matches that follow are ignored until the block is armed again.
- R11: An arm in ST_IDLE or ST_HUNT restarts the hunt at stage 0 and clears timeout_o. An arm during ST_FIRE is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| probe_i | input | NUM_SIG*SIG_W | Probed signals, signal k at bits [k*SIG_W +: SIG_W] |
| arm_i | input | 1 | Start or restart the hunt |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_field_i | input | 3 | Field code |
| cfg_stage_i | input | STG_W | Stage index of the write |
| cfg_sig_i | input | SIG_IW | Signal index of the write |
| cfg_data_i | input | CFG_W | Write data |
| trig_o | output | 1 | One-cycle trigger pulse |
| busy_o | output | 1 | Hunt in progress |
| timeout_o | output | 1 | Sticky stage-limit expiry flag |
| stage_o | output | STG_W | Stage being evaluated |

## Verification
The assertions assume that configuration is not rewritten while a hunt is in progress. They also assume that the active stage count never exceeds MAX_STG. The stimulus writes all fields before arming, and it resets the block between scenarios so that every scenario starts from the default configuration. Arms are driven as single-cycle pulses while the block is idle or hunting, never during the trigger cycle.

// File: rtl/seq_trig_pkg.sv
package seq_trig_pkg;

    typedef enum logic [2:0] {
        OP_EQ = 3'd0,
        OP_NE = 3'd1,
        OP_GT = 3'd2,
        OP_GE = 3'd3,
        OP_LT = 3'd4,
        OP_LE = 3'd5
    } cmp_op_e;

    typedef enum logic [2:0] {
        F_VAL    = 3'd0,
        F_MASK   = 3'd1,
        F_SIGCTL = 3'd2,
        F_COMB   = 3'd3,
        F_LIMIT  = 3'd4,
        F_COUNT  = 3'd5,
        F_RUNNOW = 3'd6
    } cfg_field_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_FIRE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/seq_trig_cmp.sv
module seq_trig_cmp
    import seq_trig_pkg::*;
#(
    parameter int SIG_W = 8
) (
    input  logic [SIG_W-1:0] a_i,
    input  logic [SIG_W-1:0] b_i,
    input  logic [SIG_W-1:0] mask_i,
    input  logic [2:0]       op_i,
    output logic             hit_o
);
    logic eq;

    always_comb begin
        eq = ((a_i ^ b_i) & mask_i) == '0;
        case (op_i)
            OP_EQ:   hit_o = eq;
            OP_NE:   hit_o = !eq;
            OP_GT:   hit_o = a_i >  b_i;
            OP_GE:   hit_o = a_i >= b_i;
            OP_LT:   hit_o = a_i <  b_i;
            OP_LE:   hit_o = a_i <= b_i;
            default: hit_o = 1'b0;
        endcase
    end

    // R6
    always_comb begin
        if (op_i == OP_EQ && mask_i == '0) begin
            eq_nocare_chk: assert (hit_o);
        end
    end

endmodule

// File: rtl/seq_trig_eval.sv
module seq_trig_eval
    import seq_trig_pkg::*;
#(
    parameter int NUM_SIG = 2,
    parameter int SIG_W   = 8
) (
    input  logic [NUM_SIG*SIG_W-1:0] probe_i,
    input  logic [NUM_SIG*SIG_W-1:0] val_i,
    input  logic [NUM_SIG*SIG_W-1:0] mask_i,
    input  logic [NUM_SIG-1:0]       en_i,
    input  logic [NUM_SIG*3-1:0]     op_i,
    input  logic                     or_mode_i,
    output logic                     match_o
);
    logic [NUM_SIG-1:0] hit;

    for (genvar k = 0; k < NUM_SIG; k++) begin : g_cmp
        seq_trig_cmp #(.SIG_W(SIG_W)) u_cmp (
            .a_i    (probe_i[k*SIG_W +: SIG_W]),
            .b_i    (val_i[k*SIG_W +: SIG_W]),
            .mask_i (mask_i[k*SIG_W +: SIG_W]),
            .op_i   (op_i[k*3 +: 3]),
            .hit_o  (hit[k])
        );
    end

    always_comb begin
        if (en_i == '0)
            match_o = 1'b1;
        else if (or_mode_i)
            match_o = |(hit & en_i);
        else
            match_o = &(hit | ~en_i);
    end

endmodule

// File: rtl/seq_trig_cfg.sv
module seq_trig_cfg
    import seq_trig_pkg::*;
#(
    parameter int NUM_SIG = 2,
    parameter int SIG_W   = 8,
    parameter int MAX_STG = 4,
    parameter int TMO_W   = 16,
    parameter int STG_W   = 2,
    parameter int SIG_IW  = 1,
    parameter int CFG_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [2:0]               field_i,
    input  logic [STG_W-1:0]         stage_i,
    input  logic [SIG_IW-1:0]        sig_i,
    input  logic [CFG_W-1:0]         data_i,
    input  logic [STG_W-1:0]         sel_i,
    output logic [NUM_SIG*SIG_W-1:0] val_o,
    output logic [NUM_SIG*SIG_W-1:0] mask_o,
    output logic [NUM_SIG-1:0]       en_o,
    output logic [NUM_SIG*3-1:0]     op_o,
    output logic                     or_mode_o,
    output logic [TMO_W-1:0]         limit_o,
    output logic [STG_W-1:0]         last_o,
    output logic                     run_now_o
);
    logic [SIG_W-1:0] val_q  [MAX_STG][NUM_SIG];
    logic [SIG_W-1:0] mask_q [MAX_STG][NUM_SIG];
    logic [2:0]       op_q   [MAX_STG][NUM_SIG];
    logic             en_q   [MAX_STG][NUM_SIG];
    logic             comb_q [MAX_STG];
    logic [TMO_W-1:0] lim_q  [MAX_STG];
    logic [STG_W-1:0] last_q;
    logic             run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < MAX_STG; s++) begin
                comb_q[s] <= 1'b0;
                lim_q[s]  <= '0;
                for (int k = 0; k < NUM_SIG; k++) begin
                    val_q[s][k]  <= '0;
                    mask_q[s][k] <= '1;
                    op_q[s][k]   <= OP_EQ;
                    en_q[s][k]   <= 1'b0;
                end
            end
            last_q <= STG_W'(MAX_STG - 1);
            run_q  <= 1'b0;
        end else if (we_i) begin
            case (cfg_field_e'(field_i))
                F_VAL:    val_q[stage_i][sig_i]  <= data_i[SIG_W-1:0];
                F_MASK:   mask_q[stage_i][sig_i] <= data_i[SIG_W-1:0];
                F_SIGCTL: begin
                    en_q[stage_i][sig_i] <= data_i[0];
                    op_q[stage_i][sig_i] <= data_i[3:1];
                end
                F_COMB:   comb_q[stage_i] <= data_i[0];
                F_LIMIT:  lim_q[stage_i]  <= data_i[TMO_W-1:0];
                F_COUNT:  last_q          <= data_i[STG_W-1:0];
                F_RUNNOW: run_q           <= data_i[0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        for (int k = 0; k < NUM_SIG; k++) begin
            val_o[k*SIG_W +: SIG_W]  = val_q[sel_i][k];
            mask_o[k*SIG_W +: SIG_W] = mask_q[sel_i][k];
            op_o[k*3 +: 3]           = op_q[sel_i][k];
            en_o[k]                  = en_q[sel_i][k];
        end
        or_mode_o = comb_q[sel_i];
        limit_o   = lim_q[sel_i];
        last_o    = last_q;
        run_now_o = run_q;
    end

endmodule

// File: rtl/seq_trig.sv
module seq_trig
    import seq_trig_pkg::*;
#(
    parameter int NUM_SIG = 2,
    parameter int SIG_W   = 8,
    parameter int MAX_STG = 4,
    parameter int TMO_W   = 16,
    parameter int STG_W   = (MAX_STG > 1) ? $clog2(MAX_STG) : 1,
    parameter int SIG_IW  = (NUM_SIG > 1) ? $clog2(NUM_SIG) : 1,
    parameter int CFG_W   = (SIG_W > TMO_W) ? SIG_W : TMO_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SIG*SIG_W-1:0] probe_i,
    input  logic                     arm_i,
    input  logic                     cfg_we_i,
    input  logic [2:0]               cfg_field_i,
    input  logic [STG_W-1:0]         cfg_stage_i,
    input  logic [SIG_IW-1:0]        cfg_sig_i,
    input  logic [CFG_W-1:0]         cfg_data_i,
    output logic                     trig_o,
    output logic                     busy_o,
    output logic                     timeout_o,
    output logic [STG_W-1:0]         stage_o
);
    seq_state_e state_q, state_d;
    logic [STG_W-1:0] stg_q, stg_d;
    logic [TMO_W-1:0] cnt_q, cnt_d;
    logic             tmo_q, tmo_d;

    logic [NUM_SIG*SIG_W-1:0] s_val, s_mask;
    logic [NUM_SIG-1:0]       s_en;
    logic [NUM_SIG*3-1:0]     s_op;
    logic                     s_or, run_now, match;
    logic [TMO_W-1:0]         s_lim;
    logic [STG_W-1:0]         last_stg;

    seq_trig_cfg #(
        .NUM_SIG(NUM_SIG), .SIG_W(SIG_W), .MAX_STG(MAX_STG), .TMO_W(TMO_W),
        .STG_W(STG_W), .SIG_IW(SIG_IW), .CFG_W(CFG_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .field_i(cfg_field_i),
        .stage_i(cfg_stage_i), .sig_i(cfg_sig_i), .data_i(cfg_data_i),
        .sel_i(stg_q), .val_o(s_val), .mask_o(s_mask), .en_o(s_en),
        .op_o(s_op), .or_mode_o(s_or), .limit_o(s_lim), .last_o(last_stg),
        .run_now_o(run_now)
    );

    seq_trig_eval #(.NUM_SIG(NUM_SIG), .SIG_W(SIG_W)) u_eval (
        .probe_i(probe_i), .val_i(s_val), .mask_i(s_mask), .en_i(s_en),
        .op_i(s_op), .or_mode_i(s_or), .match_o(match)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        stg_d   = stg_q;
        cnt_d   = cnt_q;
        tmo_d   = tmo_q;
        if (arm_i && state_q != ST_FIRE) begin
            stg_d   = '0;
            cnt_d   = '0;
            tmo_d   = 1'b0;
            state_d = run_now ? ST_FIRE : ST_HUNT;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_HUNT: begin
                    if (match) begin
                        cnt_d = '0;
                        if (stg_q >= last_stg) state_d = ST_FIRE;
                        else                   stg_d   = stg_q + 1'b1;
                    end else if (s_lim != '0 && cnt_q == s_lim - 1'b1) begin
                        state_d = ST_IDLE;
                        tmo_d   = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_FIRE: state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            stg_q   <= '0;
            cnt_q   <= '0;
            tmo_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            stg_q   <= stg_d;
            cnt_q   <= cnt_d;
            tmo_q   <= tmo_d;
        end
    end

    // outputs
    always_comb begin
        trig_o    = (state_q == ST_FIRE);
        busy_o    = (state_q == ST_HUNT);
        timeout_o = tmo_q;
        stage_o   = stg_q;
    end

    // R10
    trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    // R2
    stage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$past(arm_i)) |->
        (stage_o == $past(stage_o) || stage_o == $past(stage_o) + 1'b1));

    // R8
    tmo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> (!busy_o && $past(busy_o)));

    // R9
    trig_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> ($past(busy_o) || $past(arm_i)));

endmodule

// File: tb/seq_trig_test.sv
module seq_trig_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] probe = '0;
    logic        arm = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  field = '0;
    logic [1:0]  stg = '0;
    logic [0:0]  sig = '0;
    logic [15:0] data = '0;
    logic        trig, busy, tmo;
    logic [1:0]  stage;
    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    seq_trig uut (
        .clk(clk), .rst_n(rst_n), .probe_i(probe), .arm_i(arm),
        .cfg_we_i(we), .cfg_field_i(field), .cfg_stage_i(stg),
        .cfg_sig_i(sig), .cfg_data_i(data), .trig_o(trig), .busy_o(busy),
        .timeout_o(tmo), .stage_o(stage)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0; arm = 1'b0; we = 1'b0; probe = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int f, input int s, input int g, input int d);
        @(negedge clk);
        we = 1'b1; field = 3'(f); stg = 2'(s); sig = 1'(g); data = 16'(d);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic do_arm;
        @(negedge clk);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic cyc(input logic [15:0] p);
        probe = p;
        @(negedge clk);
    endtask

    task automatic t_reset;
        do_reset();
        chk("R1 trig", int'(trig), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 timeout", int'(tmo), 0);
        chk("R1 stage", int'(stage), 0);
    endtask

    // empty stages, default count of 4
    task automatic t_empty;
        do_reset();
        do_arm();
        for (int i = 1; i < 4; i++) begin
            cyc(16'h1234);
            chk("R4 R3 empty stage advance", int'(stage), i);
            chk("R3 no early trig", int'(trig), 0);
        end
        cyc(16'h1234);
        chk("R3 R4 trig after 4 stages", int'(trig), 1);
    endtask

    task automatic t_single_eq;
        do_reset();
        wr(5, 0, 0, 0);
        wr(0, 0, 0, 8'h55);
        wr(2, 0, 0, 1);
        do_arm();
        chk("R2 busy after arm", int'(busy), 1);
        cyc(16'h0011);
        chk("R5 eq miss", int'(trig), 0);
        cyc(16'hEE55);
        chk("R10 trig after match", int'(trig), 1);
        chk("R10 busy low", int'(busy), 0);
        cyc(16'h0055);
        chk("R10 match ignored", int'(trig), 0);
    endtask

    task automatic t_mask;
        do_reset();
        wr(5, 0, 0, 0);
        wr(0, 0, 1, 8'hA0);
        wr(1, 0, 1, 8'hF0);
        wr(2, 0, 1, 1);
        do_arm();
        cyc(16'hB7A7);
        chk("R6 masked miss", int'(trig), 0);
        cyc(16'hA7FF);
        chk("R6 R4 masked hit, sig0 excluded", int'(trig), 1);
    endtask

    task automatic t_comb(input bit use_or);
        do_reset();
        wr(5, 0, 0, 0);
        wr(0, 0, 0, 7);
        wr(2, 0, 0, (2 << 1) | 1);
        wr(0, 0, 1, 1);
        wr(2, 0, 1, 1);
        wr(3, 0, 0, int'(use_or));
        do_arm();
        if (!use_or) begin
            cyc(16'h0008);
            chk("R7 AND one term", int'(trig), 0);
            cyc(16'h0107);
            chk("R7 R5 AND gt fails", int'(trig), 0);
            cyc(16'h0108);
            chk("R7 AND both", int'(trig), 1);
        end else begin
            cyc(16'h0000);
            chk("R7 OR none", int'(trig), 0);
            cyc(16'h0100);
            chk("R7 OR one term", int'(trig), 1);
        end
    endtask

    task automatic t_seq;
        do_reset();
        wr(5, 0, 0, 1);
        wr(0, 0, 0, 7);
        wr(2, 0, 0, 1);
        wr(0, 1, 0, 15);
        wr(2, 1, 0, (2 << 1) | 1);
        do_arm();
        cyc(16'd20);
        chk("R2 out of order", int'(stage), 0);
        chk("R2 no trig", int'(trig), 0);
        cyc(16'd7);
        chk("R2 advance", int'(stage), 1);
        chk("R3 not last", int'(trig), 0);
        cyc(16'd7);
        chk("R2 stage1 miss", int'(trig), 0);
        cyc(16'd16);
        chk("R2 R3 last stage trig", int'(trig), 1);
    endtask

    task automatic t_timeout;
        do_reset();
        wr(5, 0, 0, 0);
        wr(0, 0, 0, 9);
        wr(2, 0, 0, 1);
        wr(4, 0, 0, 3);
        do_arm();
        cyc(16'd0);
        cyc(16'd0);
        chk("R8 busy before limit", int'(busy), 1);
        chk("R8 no flag yet", int'(tmo), 0);
        cyc(16'd0);
        chk("R8 busy dropped", int'(busy), 0);
        chk("R8 flag set", int'(tmo), 1);
        cyc(16'd9);
        chk("R8 match after abort", int'(trig), 0);
        chk("R8 flag held", int'(tmo), 1);
        do_arm();
        chk("R11 flag cleared", int'(tmo), 0);
        cyc(16'd0);
        cyc(16'd0);
        cyc(16'd9);
        chk("R8 match on last allowed cycle", int'(trig), 1);
    endtask

    task automatic t_runnow;
        do_reset();
        wr(0, 0, 0, 9);
        wr(2, 0, 0, 1);
        wr(6, 0, 0, 1);
        do_arm();
        chk("R9 immediate trig", int'(trig), 1);
        cyc(16'd0);
        chk("R9 single pulse", int'(trig), 0);
    endtask

    task automatic t_rearm;
        do_reset();
        wr(5, 0, 0, 1);
        wr(0, 0, 0, 7);
        wr(2, 0, 0, 1);
        wr(0, 1, 0, 9);
        wr(2, 1, 0, 1);
        do_arm();
        cyc(16'd7);
        chk("R2 at stage 1", int'(stage), 1);
        do_arm();
        chk("R11 restart stage", int'(stage), 0);
        chk("R11 busy", int'(busy), 1);
    endtask

    task automatic op_case(input int op, input int v, input int p, input int exp);
        do_reset();
        wr(5, 0, 0, 0);
        wr(0, 0, 0, v);
        wr(2, 0, 0, (op << 1) | 1);
        do_arm();
        cyc(16'(p));
        chk($sformatf("R5 op %0d val %0d probe %0d", op, v, p), int'(trig), exp);
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_empty();
        t_single_eq();
        t_mask();
        t_comb(1'b0);
        t_comb(1'b1);
        t_seq();
        t_timeout();
        t_runnow();
        t_rearm();
        op_case(1, 5, 5, 0);
        op_case(1, 5, 6, 1);
        op_case(2, 100, 200, 1);
        op_case(3, 5, 5, 1);
        op_case(4, 5, 5, 0);
        op_case(4, 5, 4, 1);
        op_case(5, 5, 5, 1);
        op_case(6, 5, 5, 0);
        op_case(7, 5, 5, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule